// File: doc/BRIEF.md
# Debug Command Execution Engine

This block carries out debug commands on behalf of a host debugger. The serial link in front of it has already unpacked each command into an opcode, a size code, a register selector, an address word and a data word. The engine accepts one command at a time on a valid/ready port. It executes the command against its own register state or a simple memory bus, then returns one result word and an error flag on a valid/ready response port.

Memory commands issue one request on a request/acknowledge bus. Each request carries a 3-bit address-space code taken from a source or destination space register. Two cursors, one for reads and one for writes, remember where the last memory access went. Block transfers can therefore step onward without resending the address. A fixed-length peripheral reset pulse, a resume sequence (flush strobe, then resume strobe) and a patch call (stack the program counter, then jump) complete the command set. Control leaves the engine only as strobes plus a program-counter value.

The controller has six states. IDLE accepts a command and either answers it at once (go to REPLY) or goes to BUS, FLUSH or REPLY. BUS holds a memory request until acknowledge, which goes to PATCH after a patch call and to REPLY otherwise; a bus error always goes to REPLY. FLUSH always goes to RESUME, and RESUME goes to REPLY. PATCH goes to REPLY. REPLY holds the result until it is taken and then returns to IDLE.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcode 2 writes the data word into the general register picked by the selector (0-7 data, 8-15 address; 15 is the stack pointer). Opcode 1 returns that register. Both reply without error, and every general register resets to 0.
- R2: Opcodes 3 (read) and 4 (write) reach the system registers by selector: 0 is the program counter, 1 the source space (low 3 bits kept), 2 the destination space (low 3 bits kept), 3 the fault address (writes ignored), and 4-7 are scratch. A selector of 8 or more replies with an error.
- R3: Opcode 5 issues one bus read at the given address and size, in the source space. Size codes are 0 byte, 1 word, 2 long. The reply holds the read data with the bits above the size cleared. Size code 3 replies with an error and makes no bus access.
- R4: Opcode 6 issues one bus write in the destination space. Its data has the bits above the size cleared.
- R5: Opcode 7 reads at the last read address plus the last read size in bytes (1, 2 or 4), with that size. Opcode 8 does the same for writes, using the write cursor. Each command moves its cursor onward.
- R6: Opcode 7 before any opcode-5 command, or opcode 8 before any opcode-6 command since reset, replies with an error and makes no bus access.
- R7: A bus error ends the command with an error reply and data 0. Every finished bus cycle loads its address into the fault-address register, so after a fault that register holds the faulting address until the next bus cycle.
- R8: Opcode 11 replies at once. The peripheral reset output is then high for exactly 512 cycles, starting the cycle after the command is taken. Issuing it again while the pulse runs restarts the count. Register state is untouched and commands keep being served during the pulse.
- R9: Opcode 9 raises the flush strobe for one cycle and the resume strobe in the very next cycle, with the program counter on go_pc. It then replies.
- R10: Opcode 10 writes the program counter as a long word, in the destination space, to the address in register 15. After acknowledge it raises the patch strobe for one cycle with the command address on go_pc and loads that address into the program counter. A bus error replies with an error, with no patch strobe and no change to the program counter.
- R11: Opcode 0 replies data 0 without error and changes nothing. Opcodes 12-15 reply with an error.
- R12: A command is taken only in IDLE, one at a time. The reply stays valid and stable until it is taken, and no new command is taken meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 4 | Opcode |
| cmd_size | input | 2 | Size code |
| cmd_sel | input | 4 | Register selector |
| cmd_addr | input | 32 | Address / patch target |
| cmd_data | input | 32 | Data operand |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_data | output | 32 | Reply data |
| rsp_err | output | 1 | Reply error flag |
| mem_req | output | 1 | Bus request, held until acknowledge or error |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Bus address |
| mem_size | output | 2 | Bus size code |
| mem_space | output | 3 | Address-space code |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, right-justified |
| mem_ack | input | 1 | Bus cycle finished |
| mem_berr | input | 1 | Bus cycle faulted |
| periph_rst | output | 1 | Peripheral reset pulse |
| flush_strobe | output | 1 | Pipeline flush request |
| resume_strobe | output | 1 | Resume execution request |
| patch_strobe | output | 1 | Jump to patch code request |
| go_pc | output | 32 | Program counter for resume or patch |

## Verification
Memory reads run with byte, word and long sizes at addresses whose upper bytes hold non-zero data. This shows whether the size mask works and whether the bus size follows the command. Block transfers start after byte, word and long set-up commands and go two steps out. This separates a size-sized step from a fixed one, and the read cursor from the write cursor. Faulting addresses come before and after a good cycle, to show that the fault address is captured and then overwritten. The reset pulse is measured both alone and after a restart in mid-pulse.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_RDAR  = 4'd1,
        OP_WRAR  = 4'd2,
        OP_RDSYS = 4'd3,
        OP_WRSYS = 4'd4,
        OP_READ  = 4'd5,
        OP_WRITE = 4'd6,
        OP_DUMP  = 4'd7,
        OP_FILL  = 4'd8,
        OP_GO    = 4'd9,
        OP_CALL  = 4'd10,
        OP_RST   = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BUS,
        S_FLUSH,
        S_RESUME,
        S_PATCH,
        S_REPLY
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    localparam int SYS_N   = 8;
    localparam int SYS_PC  = 0;
    localparam int SYS_SRC = 1;
    localparam int SYS_DST = 2;
    localparam int SYS_FLT = 3;

endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr,
    output logic [W-1:0]         rdata,
    output logic [W-1:0]         top_q
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata = regs_q[raddr];
    assign top_q = regs_q[N-1];
endmodule

// File: rtl/dbg_pulse_timer.sv
module dbg_pulse_timer #(
    parameter int CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/dbg_block_cursor.sv
module dbg_block_cursor #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [1:0]    load_size,
    input  logic          step,
    output logic          valid,
    output logic [AW-1:0] next_addr,
    output logic [1:0]    size_q
);
    logic [AW-1:0] addr_q;

    assign next_addr = addr_q + (AW'(1) << size_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= 2'd0;
            valid  <= 1'b0;
        end else if (load) begin
            addr_q <= load_addr;
            size_q <= load_size;
            valid  <= 1'b1;
        end else if (step) begin
            addr_q <= next_addr;
        end
    end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NREG       = 16,
    parameter int SPACE_W    = 3,
    parameter int RST_CYCLES = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [3:0]              cmd_op,
    input  logic [1:0]              cmd_size,
    input  logic [$clog2(NREG)-1:0] cmd_sel,
    input  logic [AW-1:0]           cmd_addr,
    input  logic [DW-1:0]           cmd_data,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [DW-1:0]           rsp_data,
    output logic                    rsp_err,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [1:0]              mem_size,
    output logic [SPACE_W-1:0]      mem_space,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ack,
    input  logic                    mem_berr,
    output logic                    periph_rst,
    output logic                    flush_strobe,
    output logic                    resume_strobe,
    output logic                    patch_strobe,
    output logic [AW-1:0]           go_pc
);
    localparam int SELW = $clog2(NREG);

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] s);
        case (s)
            SZ_BYTE: return DW'(8'hFF);
            SZ_WORD: return DW'(16'hFFFF);
            default: return '1;
        endcase
    endfunction

    state_e state_q, state_d;

    // bus and reply registers
    logic [AW-1:0]      addr_q, tgt_q, far_q, pc_q;
    logic [1:0]         size_q;
    logic               we_q, patch_q;
    logic [DW-1:0]      wdata_q, rsp_data_q;
    logic               rsp_err_q;
    logic [SPACE_W-1:0] space_q, src_q, dst_q;
    logic [DW-1:0]      scr_q [SYS_N-4];

    // decode controls
    logic               rf_we, rd_load, rd_step, wr_load, wr_step;
    logic               bus_go, patch_d, rsp_load, rsp_err_d, sys_we;
    logic               timer_start, far_load, pc_from_tgt;
    logic [AW-1:0]      bus_addr_d;
    logic [1:0]         bus_size_d;
    logic               bus_we_d;
    logic [DW-1:0]      bus_wdata_d, rsp_data_d, sys_rdata;
    logic [SPACE_W-1:0] bus_space_d;

    logic [DW-1:0]      rf_rdata, rf_top;
    logic               rd_valid, wr_valid;
    logic [AW-1:0]      rd_next, wr_next;
    logic [1:0]         rd_size, wr_size;
    logic               sys_ok;

    dbg_regfile #(.N(NREG), .W(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(cmd_sel), .wdata(cmd_data),
        .raddr(cmd_sel), .rdata(rf_rdata), .top_q(rf_top)
    );

    dbg_block_cursor #(.AW(AW)) u_rd_cur (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .load_addr(cmd_addr),
        .load_size(cmd_size), .step(rd_step), .valid(rd_valid),
        .next_addr(rd_next), .size_q(rd_size)
    );

    dbg_block_cursor #(.AW(AW)) u_wr_cur (
        .clk(clk), .rst_n(rst_n), .load(wr_load), .load_addr(cmd_addr),
        .load_size(cmd_size), .step(wr_step), .valid(wr_valid),
        .next_addr(wr_next), .size_q(wr_size)
    );

    dbg_pulse_timer #(.CYCLES(RST_CYCLES)) u_prst (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .pulse(periph_rst)
    );

    assign sys_ok = (cmd_sel < SELW'(SYS_N));

    always_comb begin
        case (int'(cmd_sel))
            SYS_PC:  sys_rdata = DW'(pc_q);
            SYS_SRC: sys_rdata = DW'(src_q);
            SYS_DST: sys_rdata = DW'(dst_q);
            SYS_FLT: sys_rdata = DW'(far_q);
            default: sys_rdata = scr_q[cmd_sel[1:0]];
        endcase
    end

    // next state and decode
    always_comb begin
        state_d     = state_q;
        rf_we       = 1'b0;
        rd_load     = 1'b0;
        rd_step     = 1'b0;
        wr_load     = 1'b0;
        wr_step     = 1'b0;
        bus_go      = 1'b0;
        patch_d     = 1'b0;
        rsp_load    = 1'b0;
        rsp_err_d   = 1'b0;
        rsp_data_d  = '0;
        sys_we      = 1'b0;
        timer_start = 1'b0;
        far_load    = 1'b0;
        pc_from_tgt = 1'b0;
        bus_addr_d  = cmd_addr;
        bus_size_d  = cmd_size;
        bus_we_d    = 1'b0;
        bus_wdata_d = cmd_data & lane_mask(cmd_size);
        bus_space_d = src_q;
        unique case (state_q)
            S_IDLE: if (cmd_valid) begin
                state_d  = S_REPLY;
                rsp_load = 1'b1;
                case (cmd_op)
                    OP_NOP:   ;
                    OP_RDAR:  rsp_data_d = rf_rdata;
                    OP_WRAR:  rf_we = 1'b1;
                    OP_RDSYS: if (sys_ok) rsp_data_d = sys_rdata; else rsp_err_d = 1'b1;
                    OP_WRSYS: if (sys_ok) sys_we = 1'b1; else rsp_err_d = 1'b1;
                    OP_READ: begin
                        if (cmd_size == SZ_BAD) rsp_err_d = 1'b1;
                        else begin
                            bus_go = 1'b1; rsp_load = 1'b0; state_d = S_BUS;
                            rd_load = 1'b1;
                        end
                    end
                    OP_WRITE: begin
                        if (cmd_size == SZ_BAD) rsp_err_d = 1'b1;
                        else begin
                            bus_go = 1'b1; rsp_load = 1'b0; state_d = S_BUS;
                            bus_we_d = 1'b1; bus_space_d = dst_q; wr_load = 1'b1;
                        end
                    end
                    OP_DUMP: begin
                        if (!rd_valid) rsp_err_d = 1'b1;
                        else begin
                            bus_go = 1'b1; rsp_load = 1'b0; state_d = S_BUS;
                            bus_addr_d = rd_next; bus_size_d = rd_size; rd_step = 1'b1;
                        end
                    end
                    OP_FILL: begin
                        if (!wr_valid) rsp_err_d = 1'b1;
                        else begin
                            bus_go = 1'b1; rsp_load = 1'b0; state_d = S_BUS;
                            bus_addr_d = wr_next; bus_size_d = wr_size;
                            bus_wdata_d = cmd_data & lane_mask(wr_size);
                            bus_we_d = 1'b1; bus_space_d = dst_q; wr_step = 1'b1;
                        end
                    end
                    OP_GO: begin
                        rsp_load = 1'b0; state_d = S_FLUSH;
                    end
                    OP_CALL: begin
                        bus_go = 1'b1; rsp_load = 1'b0; state_d = S_BUS;
                        bus_addr_d = AW'(rf_top); bus_size_d = SZ_LONG;
                        bus_wdata_d = DW'(pc_q); bus_we_d = 1'b1;
                        bus_space_d = dst_q; patch_d = 1'b1;
                    end
                    OP_RST:   timer_start = 1'b1;
                    default:  rsp_err_d = 1'b1;
                endcase
            end
            S_BUS: begin
                if (mem_berr) begin
                    state_d = S_REPLY; rsp_load = 1'b1; rsp_err_d = 1'b1; far_load = 1'b1;
                end else if (mem_ack) begin
                    far_load = 1'b1; rsp_load = 1'b1;
                    rsp_data_d = we_q ? '0 : (mem_rdata & lane_mask(size_q));
                    state_d = patch_q ? S_PATCH : S_REPLY;
                end
            end
            S_FLUSH:  state_d = S_RESUME;
            S_RESUME: begin
                state_d = S_REPLY; rsp_load = 1'b1;
            end
            S_PATCH: begin
                state_d = S_REPLY; pc_from_tgt = 1'b1;
            end
            S_REPLY:  if (rsp_ready) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            tgt_q      <= '0;
            size_q     <= SZ_LONG;
            we_q       <= 1'b0;
            patch_q    <= 1'b0;
            wdata_q    <= '0;
            space_q    <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
            far_q      <= '0;
            pc_q       <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            for (int i = 0; i < SYS_N - 4; i++) scr_q[i] <= '0;
        end else begin
            if (bus_go) begin
                addr_q  <= bus_addr_d;
                size_q  <= bus_size_d;
                we_q    <= bus_we_d;
                wdata_q <= bus_wdata_d;
                space_q <= bus_space_d;
                patch_q <= patch_d;
                tgt_q   <= cmd_addr;
            end
            if (rsp_load) begin
                rsp_data_q <= rsp_data_d;
                rsp_err_q  <= rsp_err_d;
            end
            if (far_load)    far_q <= addr_q;
            if (pc_from_tgt) pc_q  <= tgt_q;
            if (sys_we) begin
                case (int'(cmd_sel))
                    SYS_PC:  pc_q  <= AW'(cmd_data);
                    SYS_SRC: src_q <= cmd_data[SPACE_W-1:0];
                    SYS_DST: dst_q <= cmd_data[SPACE_W-1:0];
                    SYS_FLT: ;
                    default: scr_q[cmd_sel[1:0]] <= cmd_data;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready     = (state_q == S_IDLE);
        rsp_valid     = (state_q == S_REPLY);
        rsp_data      = rsp_data_q;
        rsp_err       = rsp_err_q;
        mem_req       = (state_q == S_BUS);
        mem_we        = we_q;
        mem_addr      = addr_q;
        mem_size      = size_q;
        mem_space     = space_q;
        mem_wdata     = wdata_q;
        flush_strobe  = (state_q == S_FLUSH);
        resume_strobe = (state_q == S_RESUME);
        patch_strobe  = (state_q == S_PATCH);
        go_pc         = (state_q == S_PATCH) ? tgt_q : pc_q;
    end
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk
    import dbg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int RST_CYCLES = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [3:0]    cmd_op,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_err,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          mem_berr,
    input logic          periph_rst,
    input logic          flush_strobe,
    input logic          resume_strobe,
    input logic          patch_strobe,
    input logic [AW-1:0] far_q
);
    logic        rst_take;
    logic [31:0] hi_cnt;

    assign rst_take = cmd_valid && cmd_ready && (cmd_op == OP_RST);

    // high cycles of the peripheral reset since the last reset command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (rst_take)   hi_cnt <= '0;
        else if (periph_rst) hi_cnt <= hi_cnt + 1;
    end

    a_r12_reply_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

    a_r12_no_take_while_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && rsp_valid));

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mem_berr |=> mem_req && $stable(mem_addr));

    a_r9_resume_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        resume_strobe |-> $past(flush_strobe));

    a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_strobe |=> !flush_strobe);

    a_r10_patch_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        patch_strobe |-> $past(mem_ack) && !$past(mem_berr));

    a_r7_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_berr |=> far_q == $past(mem_addr));

    a_r8_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst) |-> hi_cnt == RST_CYCLES);

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= RST_CYCLES);
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.AW(AW), .DW(DW), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_berr(mem_berr),
    .periph_rst(periph_rst), .flush_strobe(flush_strobe), .resume_strobe(resume_strobe),
    .patch_strobe(patch_strobe), .far_q(far_q)
);

// File: tb/tb_dbg_cmd_engine.sv
module tb_dbg_cmd_engine;
    import dbg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_size = '0;
    logic [3:0]  cmd_sel = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [2:0]  mem_space;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_berr = 1'b0;
    logic        periph_rst, flush_strobe, resume_strobe, patch_strobe;
    logic [31:0] go_pc;

    always #4 clk = ~clk;

    dbg_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_space(mem_space),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_berr(mem_berr), .periph_rst(periph_rst), .flush_strobe(flush_strobe),
        .resume_strobe(resume_strobe), .patch_strobe(patch_strobe), .go_pc(go_pc)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    logic [7:0]  mem [256];
    int          lat = 0, bus_n = 0;
    logic [31:0] last_addr = '0;
    logic [2:0]  last_space = '0;
    logic [1:0]  last_size = '0;
    logic        last_we = 1'b0;
    int flush_n = 0, resume_n = 0, patch_n = 0, flush_cyc = 0, resume_cyc = 0;
    logic [31:0] resume_pc = '0, patch_pc = '0;
    int rst_acc_cyc = 0, run = 0, last_run = 0, len_from_acc = 0, falls = 0;
    logic prev_prst = 1'b0;
    logic [31:0] r;
    logic        e;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: answers after two waiting cycles, faults on 0xE... addresses
    always @(negedge clk) begin
        if (mem_ack || mem_berr) begin
            mem_ack = 1'b0; mem_berr = 1'b0; lat = 0;
        end else if (mem_req) begin
            if (lat < 2) lat++;
            else begin
                bus_n++;
                last_addr = mem_addr; last_space = mem_space;
                last_size = mem_size; last_we = mem_we;
                if (mem_addr[31:28] == 4'hE) mem_berr = 1'b1;
                else begin
                    mem_ack = 1'b1;
                    for (int i = 0; i < 4; i++) begin
                        if (mem_we) begin
                            if (i < (1 << mem_size)) mem[mem_addr[7:0] + 8'(i)] = mem_wdata[8*i +: 8];
                        end else begin
                            mem_rdata[8*i +: 8] = mem[mem_addr[7:0] + 8'(i)];
                        end
                    end
                end
            end
        end
    end

    // strobe and reset-pulse monitor
    always @(negedge clk) begin
        if (flush_strobe)  begin flush_n++;  flush_cyc = cyc; end
        if (resume_strobe) begin resume_n++; resume_cyc = cyc; resume_pc = go_pc; end
        if (patch_strobe)  begin patch_n++;  patch_pc = go_pc; end
        if (periph_rst) run++;
        else if (prev_prst) begin
            last_run = run; len_from_acc = cyc - rst_acc_cyc - 1; run = 0; falls++;
        end
        prev_prst = periph_rst;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [3:0] op, input logic [1:0] sz, input logic [3:0] sel,
                          input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_size = sz; cmd_sel = sel; cmd_addr = addr; cmd_data = data;
        cmd_valid = 1'b1;
        if (op == OP_RST) rst_acc_cyc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        r = rsp_data; e = rsp_err;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 ready after reset", 32'(cmd_ready), 1);
        chk("R12 no reply after reset", 32'(rsp_valid), 0);
        chk("R8 pulse low after reset", 32'(periph_rst), 0);
        chk("R3 no request after reset", 32'(mem_req), 0);
    endtask

    task automatic t_no_anchor();
        int b0 = bus_n;
        do_cmd(OP_DUMP, SZ_LONG, 0, 0, 0);
        chk("R6 dump without read errors", 32'(e), 1);
        do_cmd(OP_FILL, SZ_LONG, 0, 0, 32'h55);
        chk("R6 fill without write errors", 32'(e), 1);
        chk("R6 no bus access", bus_n, b0);
    endtask

    task automatic t_regs();
        do_cmd(OP_WRAR, 0, 3, 0, 32'h1234_5678);
        do_cmd(OP_WRAR, 0, 15, 0, 32'h60);
        do_cmd(OP_RDAR, 0, 3, 0, 0);
        chk("R1 data reg readback", r, 32'h1234_5678);
        chk("R1 no error", 32'(e), 0);
        do_cmd(OP_RDAR, 0, 15, 0, 0);
        chk("R1 address reg readback", r, 32'h60);
        do_cmd(OP_RDAR, 0, 4, 0, 0);
        chk("R1 untouched reg is zero", r, 0);
    endtask

    task automatic t_sysregs();
        do_cmd(OP_WRSYS, 0, 1, 0, 32'h9);
        do_cmd(OP_WRSYS, 0, 2, 0, 32'h2);
        do_cmd(OP_WRSYS, 0, 0, 0, 32'h1000);
        do_cmd(OP_WRSYS, 0, 5, 0, 32'hCAFE);
        do_cmd(OP_WRSYS, 0, 3, 0, 32'hDEAD);
        do_cmd(OP_RDSYS, 0, 3, 0, 0);
        chk("R2 fault address write ignored", r, 0);
        do_cmd(OP_RDSYS, 0, 1, 0, 0);
        chk("R2 source space low bits", r, 1);
        do_cmd(OP_RDSYS, 0, 5, 0, 0);
        chk("R2 scratch readback", r, 32'hCAFE);
        do_cmd(OP_RDSYS, 0, 0, 0, 0);
        chk("R2 pc readback", r, 32'h1000);
        do_cmd(OP_RDSYS, 0, 9, 0, 0);
        chk("R2 selector out of range errors", 32'(e), 1);
    endtask

    task automatic t_nop();
        int b0 = bus_n;
        do_cmd(OP_NOP, 0, 0, 0, 32'hFFFF);
        chk("R11 null ok", {r[30:0], e}, 0);
        do_cmd(4'd14, 0, 0, 0, 0);
        chk("R11 unknown opcode errors", 32'(e), 1);
        chk("R11 no bus access", bus_n, b0);
    endtask

    task automatic t_read();
        int b0;
        mem[8'h10] = 8'h11; mem[8'h11] = 8'h22; mem[8'h12] = 8'h33; mem[8'h13] = 8'h44;
        do_cmd(OP_READ, SZ_LONG, 0, 32'h10, 0);
        chk("R3 long read", r, 32'h4433_2211);
        chk("R3 source space", 32'(last_space), 1);
        chk("R3 read direction", 32'(last_we), 0);
        do_cmd(OP_READ, SZ_BYTE, 0, 32'h11, 0);
        chk("R3 byte read masked", r, 32'h22);
        do_cmd(OP_READ, SZ_WORD, 0, 32'h12, 0);
        chk("R3 word read masked", r, 32'h4433);
        chk("R3 bus size", 32'(last_size), 1);
        b0 = bus_n;
        do_cmd(OP_READ, SZ_BAD, 0, 32'h10, 0);
        chk("R3 bad size errors", 32'(e), 1);
        chk("R3 bad size no bus", bus_n, b0);
    endtask

    task automatic t_write();
        do_cmd(OP_WRITE, SZ_WORD, 0, 32'h20, 32'hAABB_CCDD);
        chk("R4 write ok", 32'(e), 0);
        chk("R4 low byte", 32'(mem[8'h20]), 32'hDD);
        chk("R4 second byte", 32'(mem[8'h21]), 32'hCC);
        chk("R4 beyond size untouched", 32'(mem[8'h22]), 0);
        chk("R4 destination space", 32'(last_space), 2);
        do_cmd(OP_WRITE, SZ_LONG, 0, 32'h24, 32'h0102_0304);
        chk("R4 long top byte", 32'(mem[8'h27]), 32'h01);
    endtask

    task automatic t_block();
        for (int i = 8'h30; i < 8'h38; i++) mem[i] = 8'(i);
        do_cmd(OP_READ, SZ_WORD, 0, 32'h30, 0);
        do_cmd(OP_DUMP, SZ_BYTE, 0, 32'hFF, 0);
        chk("R5 dump step word data", r, 32'h3332);
        chk("R5 dump step word addr", last_addr, 32'h32);
        do_cmd(OP_DUMP, 0, 0, 0, 0);
        chk("R5 dump second step", last_addr, 32'h34);
        chk("R5 dump second data", r, 32'h3534);
        do_cmd(OP_READ, SZ_BYTE, 0, 32'h36, 0);
        do_cmd(OP_DUMP, 0, 0, 0, 0);
        chk("R5 dump byte step", r, 32'h37);
        do_cmd(OP_FILL, 0, 0, 0, 32'hA1A2_A3A4);
        chk("R5 fill after long write addr", last_addr, 32'h28);
        chk("R5 fill data", 32'(mem[8'h28]), 32'hA4);
        do_cmd(OP_FILL, 0, 0, 0, 32'hB1B2_B3B4);
        chk("R5 fill second step", last_addr, 32'h2C);
        do_cmd(OP_WRITE, SZ_BYTE, 0, 32'h50, 32'h77);
        do_cmd(OP_FILL, SZ_LONG, 0, 0, 32'h1234_5688);
        chk("R5 fill byte step", 32'(mem[8'h51]), 32'h88);
        chk("R5 fill keeps byte size", 32'(mem[8'h52]), 0);
    endtask

    task automatic t_fault();
        do_cmd(OP_READ, SZ_LONG, 0, 32'hE000_0010, 0);
        chk("R7 bus error reply", 32'(e), 1);
        chk("R7 bus error data", r, 0);
        do_cmd(OP_RDSYS, 0, 3, 0, 0);
        chk("R7 fault address captured", r, 32'hE000_0010);
        do_cmd(OP_READ, SZ_LONG, 0, 32'h10, 0);
        do_cmd(OP_RDSYS, 0, 3, 0, 0);
        chk("R7 overwritten by next cycle", r, 32'h10);
    endtask

    task automatic t_go();
        do_cmd(OP_GO, 0, 0, 0, 0);
        chk("R9 reply ok", 32'(e), 0);
        chk("R9 one flush", flush_n, 1);
        chk("R9 one resume", resume_n, 1);
        chk("R9 resume next cycle", resume_cyc, flush_cyc + 1);
        chk("R9 resume pc", resume_pc, 32'h1000);
    endtask

    task automatic t_call();
        do_cmd(OP_CALL, 0, 0, 32'h2000, 0);
        chk("R10 reply ok", 32'(e), 0);
        chk("R10 stacked pc", {mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]}, 32'h1000);
        chk("R10 long size", 32'(last_size), 2);
        chk("R10 destination space", 32'(last_space), 2);
        chk("R10 patch strobe", patch_n, 1);
        chk("R10 patch pc", patch_pc, 32'h2000);
        do_cmd(OP_RDSYS, 0, 0, 0, 0);
        chk("R10 pc updated", r, 32'h2000);
        do_cmd(OP_WRAR, 0, 15, 0, 32'hE000_0000);
        do_cmd(OP_CALL, 0, 0, 32'h3000, 0);
        chk("R10 fault errors", 32'(e), 1);
        chk("R10 fault no strobe", patch_n, 1);
        do_cmd(OP_RDSYS, 0, 0, 0, 0);
        chk("R10 fault keeps pc", r, 32'h2000);
    endtask

    task automatic t_rst();
        int f0;
        do_cmd(OP_WRAR, 0, 5, 0, 32'h55);
        f0 = falls;
        do_cmd(OP_RST, 0, 0, 0, 0);
        chk("R8 reply ok", 32'(e), 0);
        chk("R8 pulse running", 32'(periph_rst), 1);
        do_cmd(OP_RDAR, 0, 5, 0, 0);
        chk("R8 registers kept during pulse", r, 32'h55);
        do_cmd(OP_WRAR, 0, 6, 0, 32'h66);
        do_cmd(OP_RDAR, 0, 6, 0, 0);
        chk("R8 commands served during pulse", r, 32'h66);
        for (int i = 0; i < 1000 && falls == f0; i++) @(negedge clk);
        chk("R8 pulse length", last_run, 512);
        chk("R8 pulse start", len_from_acc, 512);
        f0 = falls;
        do_cmd(OP_RST, 0, 0, 0, 0);
        repeat (100) @(negedge clk);
        do_cmd(OP_RST, 0, 0, 0, 0);
        for (int i = 0; i < 1500 && falls == f0; i++) @(negedge clk);
        chk("R8 restart counts from second command", len_from_acc, 512);
        chk("R8 restart extends pulse", 32'(last_run > 600), 1);
        do_cmd(OP_RDAR, 0, 5, 0, 0);
        chk("R8 registers kept after pulse", r, 32'h55);
    endtask

    task automatic t_hold();
        logic [31:0] d0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = OP_RDAR; cmd_sel = 3; cmd_valid = 1'b1;
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        d0 = rsp_data;
        cmd_op = OP_WRAR; cmd_sel = 3; cmd_data = 32'h0BAD;
        repeat (5) @(negedge clk);
        chk("R12 reply held", 32'(rsp_valid), 1);
        chk("R12 reply stable", rsp_data, d0);
        chk("R12 not ready while replying", 32'(cmd_ready), 0);
        cmd_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        do_cmd(OP_RDAR, 0, 3, 0, 0);
        chk("R12 held command not taken", r, 32'h1234_5678);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_anchor();
        t_regs();
        t_sysregs();
        t_nop();
        t_read();
        t_write();
        t_block();
        t_fault();
        t_go();
        do_cmd(OP_WRAR, 0, 15, 0, 32'h60);
        do_cmd(OP_WRSYS, 0, 0, 0, 32'h1000);
        t_call();
        t_rst();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule